// File: doc/BRIEF.md
# Serial Control Register Port

This block is the slave end of a three-wire control port. An external master selects it with an active-low select line, clocks it with a serial clock and moves data over one data line, which is split here into an input, an output and an output enable for a pad driver. Every transaction opens with one instruction byte. That byte names the direction, the number of data bytes and the register to start at. The data bytes follow, and the port steps to the next register address after each one.

The block keeps a bank of byte-wide control registers with fixed reset values, and drives all of them out in parallel to the logic they configure. It also holds one read-only revision register. Register 0 controls the port itself. One of its bits chooses the shift order, and another triggers a software reset of the rest of the bank. The serial lines are synchronised into the system clock domain, and all state advances on that clock.

Top module: `serial_regport`

## Requirements
- R1: The first byte after `sel_n` falls is the instruction: bit 7 is the direction (1 = read, 0 = write), bits 6:5 hold a count N giving N+1 data bytes, and bits 4:0 hold the start address.
- R2: `sdata_i` is sampled on rising `sclk` edges, and a byte is complete on every eighth rising edge counted from the fall of `sel_n`.
- R3: When bit 6 of register 0 is 1, the instruction byte and the data bytes in both directions are shifted bit 0 first; when that bit is 0 they are shifted bit 7 first.
- R4: A change to the shift-order bit applies from the next transaction only; the remaining bytes of the transaction that wrote it keep the old order.
- R5: Each data byte uses the address of the byte before it plus one, wrapping within 5 bits. Bytes sent after the N+1 counted bytes write nothing and are not driven out.
- R6: In a write, each register takes its new value when its own byte completes, before the next byte completes.
- R7: After the synchronous reset, registers 0 to 8 read 0x00, 0x00, 0x9F, 0x02, 0x01, 0x80, 0x00, 0x00, 0x00, and `sdata_oe` is 0.
- R8: Writing register 0 with bit 5 set returns registers 1 to 8 to their R7 values. Register 0 keeps the written byte, except that bit 5 reads as 0.
- R9: Address 15 reads {4'b0, REVISION} and ignores writes. Addresses 9 to 14 and 16 to 31 read 0x00 and ignore writes.
- R10: Raising `sel_n` before a byte completes drops the partial byte without writing anything, and the next transaction starts a fresh instruction byte.
- R11: `sdata_oe` is 1 only during the data bytes of a read, from the falling `sclk` edge after the instruction byte until the falling edge after the last counted byte. `sdata_o` changes only on falling `sclk` edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Active-low transaction select |
| sclk | input | 1 | Serial clock from the master |
| sdata_i | input | 1 | Serial data from the master |
| sdata_o | output | 1 | Serial read data to the pad |
| sdata_oe | output | 1 | Pad output enable for read data |
| reg_bank_o | output | NUM_REGS*8 | All control registers, register i in bits 8i+7:8i |

## Verification
Directed transfers cover single-byte and four-byte writes and reads, a run past the address count, the revision address and unmapped addresses. Each of these pins down address stepping, byte counting and the read mux separately. A multibyte write that starts at register 0 and sets the order bit shows whether the new order is applied too early. A soft-reset write and a select released in the middle of a byte test the two paths by which register contents can be kept or restored. A run of seeded random transactions then mixes directions, counts, addresses and random register-0 values, so both shift orders and repeated soft resets meet every other case, and the results are compared against a bench model.

// File: rtl/regport_pkg.sv
// Package for the serial register port.
// Holds the register-0 bit positions, the transfer phase type and the
// reset value function. Assumes byte-wide registers.
package regport_pkg;

    localparam int BYTE_W       = 8;
    localparam int ADDR_W       = 5;
    localparam int CFG_LSB_BIT  = 6;
    localparam int CFG_SRST_BIT = 5;
    localparam int REV_ADDR     = 15;

    typedef enum logic [1:0] {
        PH_INSTR = 2'd0,
        PH_DATA  = 2'd1,
        PH_DRAIN = 2'd2
    } phase_e;

    // Returns the reset value of register idx.
    function automatic logic [BYTE_W-1:0] reg_default(input int idx);
        case (idx)
            2:       return 8'h9F;
            3:       return 8'h02;
            4:       return 8'h01;
            5:       return 8'h80;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/regport_sync.sv
// Multi-bit synchroniser for the serial lines.
// Each bit passes through STAGES flops on clk. Assumes the serial clock is
// much slower than clk, so bits that change together arrive together.
module regport_sync #(
    parameter int              WIDTH     = 3,
    parameter int              STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First flop captures the raw lines.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[0] <= RESET_VAL;
                else        stage_q[0] <= async_i;
            end
        end else begin : g_next
            // Later flops settle metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= RESET_VAL;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/regport_shifter.sv
// Serial transfer engine.
// Counts rising sclk edges while selected, assembles bytes in the order
// latched at transaction start, decodes the instruction byte, steps the
// address, issues one write strobe per completed write byte, and drives
// read bits on falling edges. Assumes synchronised inputs.
module regport_shifter
    import regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n_s,
    input  logic              sclk_s,
    input  logic              sdi_s,
    input  logic              cfg_lsb,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sdo,
    output logic              sdo_oe
);

    logic              sclk_q;
    logic              active;
    logic              rise;
    logic              fall;
    logic [2:0]        bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] byte_next;
    logic              byte_done;
    logic              lsb_q;
    logic              rd_q;
    logic [1:0]        left_q;
    logic [ADDR_W-1:0] addr_q;
    phase_e            phase_q;
    logic [2:0]        out_idx;

    // Decodes edges and the assembled byte.
    always_comb begin
        active    = !sel_n_s;
        rise      = active && sclk_s && !sclk_q;
        fall      = active && !sclk_s && sclk_q;
        byte_next = lsb_q ? {sdi_s, shreg[BYTE_W-1:1]} : {shreg[BYTE_W-2:0], sdi_s};
        byte_done = rise && (bit_cnt == 3'd7);
        out_idx   = lsb_q ? bit_cnt : (3'd7 - bit_cnt);
    end

    assign rd_addr = addr_q;

    // Runs the transfer: counting, decoding, stepping and driving.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            bit_cnt <= '0;
            shreg   <= '0;
            lsb_q   <= 1'b0;
            rd_q    <= 1'b0;
            left_q  <= '0;
            addr_q  <= '0;
            phase_q <= PH_INSTR;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            sdo     <= 1'b0;
            sdo_oe  <= 1'b0;
        end else begin
            sclk_q <= sclk_s;
            wr_en  <= 1'b0;
            if (!active) begin
                bit_cnt <= '0;
                phase_q <= PH_INSTR;
                lsb_q   <= cfg_lsb;
                sdo_oe  <= 1'b0;
            end else begin
                if (rise) begin
                    shreg   <= byte_next;
                    bit_cnt <= bit_cnt + 3'd1;
                end
                if (byte_done) begin
                    case (phase_q)
                        PH_INSTR: begin
                            rd_q    <= byte_next[7];
                            left_q  <= byte_next[6:5];
                            addr_q  <= byte_next[4:0];
                            phase_q <= PH_DATA;
                        end
                        PH_DATA: begin
                            if (!rd_q) begin
                                wr_en   <= 1'b1;
                                wr_addr <= addr_q;
                                wr_data <= byte_next;
                            end
                            addr_q <= addr_q + 1'b1;
                            if (left_q == 2'd0) phase_q <= PH_DRAIN;
                            else                left_q  <= left_q - 2'd1;
                        end
                        default: ;
                    endcase
                end
                if (fall) begin
                    if (phase_q == PH_DATA && rd_q) begin
                        sdo_oe <= 1'b1;
                        sdo    <= rd_data[out_idx];
                    end else begin
                        sdo_oe <= 1'b0;
                    end
                end
            end
        end
    end

    p_oe_off_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n_s |=> !sdo_oe);

    p_oe_read_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> rd_q);

    p_sdo_on_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo) |-> $past(fall));

    p_write_after_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(rise));

    p_write_byte_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> bit_cnt == 3'd0);

endmodule

// File: rtl/regport_regfile.sv
// Control register bank.
// Holds NUM_REGS byte registers with fixed reset values. A write to
// register 0 with the soft-reset bit set restores registers 1 and up, and
// the bit itself is never stored. Also returns the revision at its fixed
// address. Assumes NUM_REGS <= 15 so the revision address stays free.
module regport_regfile
    import regport_pkg::*;
#(
    parameter int         NUM_REGS = 9,
    parameter logic [3:0] REVISION = 4'h3,
    localparam int        BANK_W   = NUM_REGS * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              cfg_lsb,
    output logic [BANK_W-1:0] regs_flat
);

    logic [BYTE_W-1:0] regs [NUM_REGS];
    logic              soft_rst;

    assign soft_rst = wr_en && (wr_addr == '0) && wr_data[CFG_SRST_BIT];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        if (g == 0) begin : g_cfg
            // Register 0 stores the byte with the soft-reset bit cleared.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[0] <= reg_default(0);
                else if (wr_en && wr_addr == '0)
                    regs[0] <= wr_data & ~(8'h01 << CFG_SRST_BIT);
            end
        end else begin : g_plain
            // Other registers take writes or return to their reset value.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[g] <= reg_default(g);
                else if (wr_en && wr_addr == ADDR_W'(g))
                    regs[g] <= wr_data;
                else if (soft_rst)
                    regs[g] <= reg_default(g);
            end
        end
        assign regs_flat[g*BYTE_W +: BYTE_W] = regs[g];
    end

    assign cfg_lsb = regs[0][CFG_LSB_BIT];

    // Selects read data by address.
    always_comb begin
        if (int'(rd_addr) < NUM_REGS)
            rd_data = regs[rd_addr];
        else if (int'(rd_addr) == REV_ADDR)
            rd_data = {4'h0, REVISION};
        else
            rd_data = '0;
    end

    p_soft_reset_defaults_r8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> regs[NUM_REGS-1] == reg_default(NUM_REGS-1));

    p_srst_bit_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '0) |=> !regs[0][CFG_SRST_BIT]);

    p_rev_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_addr) >= NUM_REGS) |=> $stable(regs_flat));

endmodule

// File: rtl/serial_regport.sv
// Top of the serial register port.
// Synchronises the select, clock and data lines, runs the transfer engine
// and holds the register bank, which is driven out in parallel.
// Assumes sclk is at least eight clk periods per half cycle.
module serial_regport
    import regport_pkg::*;
#(
    parameter int         NUM_REGS    = 9,
    parameter logic [3:0] REVISION    = 4'h3,
    parameter int         SYNC_STAGES = 2,
    localparam int        BANK_W      = NUM_REGS * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              sclk,
    input  logic              sdata_i,
    output logic              sdata_o,
    output logic              sdata_oe,
    output logic [BANK_W-1:0] reg_bank_o
);

    logic [2:0]        lines_s;
    logic              cfg_lsb;
    logic [BYTE_W-1:0] rd_data;
    logic [ADDR_W-1:0] rd_addr;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [BYTE_W-1:0] wr_data;

    regport_sync #(
        .WIDTH     (3),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (3'b100)
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sel_n, sclk, sdata_i}),
        .sync_o  (lines_s)
    );

    regport_shifter i_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_n_s (lines_s[2]),
        .sclk_s  (lines_s[1]),
        .sdi_s   (lines_s[0]),
        .cfg_lsb (cfg_lsb),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .sdo     (sdata_o),
        .sdo_oe  (sdata_oe)
    );

    regport_regfile #(
        .NUM_REGS (NUM_REGS),
        .REVISION (REVISION)
    ) i_regfile (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .cfg_lsb   (cfg_lsb),
        .regs_flat (reg_bank_o)
    );

endmodule

// File: tb/test_serial_regport.sv
module test_serial_regport;

    localparam int         NREG = 9;
    localparam logic [3:0] REV  = 4'h3;
    localparam int         HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1;
    logic sclk = 1'b0;
    logic sdata_i = 1'b0;
    logic sdata_o;
    logic sdata_oe;
    logic [NREG*8-1:0] reg_bank_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;
    logic [7:0] mdl [32];

    always #2 clk = ~clk;

    serial_regport #(.NUM_REGS(NREG), .REVISION(REV)) i_serial_regport (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_n      (sel_n),
        .sclk       (sclk),
        .sdata_i    (sdata_i),
        .sdata_o    (sdata_o),
        .sdata_oe   (sdata_oe),
        .reg_bank_o (reg_bank_o)
    );

    function automatic logic [7:0] dflt(input int i);
        case (i)
            2: return 8'h9F;
            3: return 8'h02;
            4: return 8'h01;
            5: return 8'h80;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] mdl_read(input logic [4:0] a);
        if (a < NREG) return mdl[a];
        if (a == 5'd15) return {4'h0, REV};
        return 8'h00;
    endfunction

    task automatic mdl_reset();
        for (int i = 0; i < 32; i++) mdl[i] = dflt(i);
    endtask

    task automatic mdl_write(input logic [4:0] a, input logic [7:0] d);
        if (a == 5'd0) begin
            mdl[0] = d & 8'hDF;
            if (d[5]) for (int i = 1; i < NREG; i++) mdl[i] = dflt(i);
        end else if (a < NREG) begin
            mdl[a] = d;
        end
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_bank(input string tag);
        for (int i = 0; i < NREG; i++)
            chk(reg_bank_o[i*8 +: 8] == mdl[i], tag, reg_bank_o[i*8 +: 8], mdl[i]);
    endtask

    // Sends one byte in the given order, collects read bits and checks the enable.
    task automatic xfer(input logic [7:0] tx, input bit lsb, input bit exp_oe,
                        input string tag, output logic [7:0] rx);
        bit oe_ok = 1;
        rx = 8'h00;
        for (int i = 0; i < 8; i++) begin
            int idx = lsb ? i : 7 - i;
            sclk = 1'b0;
            sdata_i = tx[idx];
            repeat (HALF) @(negedge clk);
            rx[idx] = sdata_o;
            if (sdata_oe !== exp_oe) oe_ok = 0;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
        end
        chk(oe_ok, {tag, " R11 oe"}, 32'(!exp_oe), 32'(exp_oe));
    endtask

    task automatic txn_end();
        sclk = 1'b0;
        repeat (HALF) @(negedge clk);
        sel_n = 1'b1;
        repeat (2*HALF) @(negedge clk);
    endtask

    // Full transaction; data is packed byte 0 in bits 7:0.
    task automatic txn(input bit rd, input logic [1:0] n, input logic [4:0] a,
                       input logic [31:0] wdata, input bit extra, input string tag);
        bit lsb = mdl[0][6];
        logic [7:0] rx;
        sel_n = 1'b0;
        repeat (HALF) @(negedge clk);
        xfer({rd, n, a}, lsb, 1'b0, {tag, " R1 instr"}, rx);
        for (int k = 0; k <= int'(n); k++) begin
            logic [4:0] ak = a + 5'(k);
            if (rd) begin
                logic [7:0] exp = mdl_read(ak);
                xfer(8'hC3, lsb, 1'b1, tag, rx);
                chk(rx == exp, {tag, " R1 R3 R5 read"}, rx, exp);
            end else begin
                xfer(wdata[k*8 +: 8], lsb, 1'b0, tag, rx);
                mdl_write(ak, wdata[k*8 +: 8]);
                check_bank({tag, " R6 commit"});
            end
        end
        if (extra) begin
            xfer(8'h25, lsb, 1'b0, {tag, " R5 extra"}, rx);
            check_bank({tag, " R5 extra ignored"});
        end
        txn_end();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        mdl_reset();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check_bank("R7 reset");
        chk(sdata_oe == 1'b0, "R7 oe", 32'(sdata_oe), 0);

        txn(1'b0, 2'd0, 5'd3, 32'h5A, 1'b0, "R2 single write");
        txn(1'b1, 2'd0, 5'd3, 0, 1'b0, "R1 single read");
        txn(1'b0, 2'd3, 5'd5, 32'h44332211, 1'b1, "R6 multi write");
        txn(1'b1, 2'd3, 5'd6, 0, 1'b1, "R5 read past end");
        txn(1'b1, 2'd0, 5'd15, 0, 1'b0, "R9 revision");
        txn(1'b0, 2'd0, 5'd15, 32'hAA, 1'b0, "R9 rev write");
        txn(1'b1, 2'd1, 5'd14, 0, 1'b0, "R9 rev after write");
        txn(1'b0, 2'd0, 5'd20, 32'h77, 1'b0, "R9 unmapped write");
        // Order bit set by byte 0; byte 1 must still be MSB first (R4).
        txn(1'b0, 2'd1, 5'd0, 32'h3340, 1'b0, "R4 order change");
        txn(1'b1, 2'd1, 5'd0, 0, 1'b0, "R3 lsb read");
        txn(1'b0, 2'd1, 5'd7, 32'h81C6, 1'b0, "R3 lsb write");
        txn(1'b1, 2'd1, 5'd7, 0, 1'b0, "R3 lsb readback");
        txn(1'b0, 2'd0, 5'd0, 32'h60, 1'b0, "R8 soft reset");
        txn(1'b1, 2'd0, 5'd0, 0, 1'b0, "R8 reg0 kept");

        // R10: abort after four bits of a data byte.
        begin
            logic [7:0] rx;
            sel_n = 1'b0;
            repeat (HALF) @(negedge clk);
            xfer({1'b0, 2'd0, 5'd4}, mdl[0][6], 1'b0, "R10 instr", rx);
            for (int i = 0; i < 4; i++) begin
                sclk = 1'b0; sdata_i = 1'b1;
                repeat (HALF) @(negedge clk);
                sclk = 1'b1;
                repeat (HALF) @(negedge clk);
            end
            txn_end();
            check_bank("R10 abort no write");
        end
        txn(1'b1, 2'd0, 5'd4, 0, 1'b0, "R10 restart");
        txn(1'b0, 2'd0, 5'd0, 32'h00, 1'b0, "R3 back to msb");
        txn(1'b1, 2'd2, 5'd2, 0, 1'b0, "R3 msb read");

        for (int t = 0; t < 100; t++) begin
            bit          rd = 1'($urandom % 2);
            logic [1:0]  n  = 2'($urandom % 4);
            logic [4:0]  a  = ($urandom % 10 < 8) ? 5'($urandom % NREG) : 5'($urandom % 32);
            logic [31:0] d  = $urandom;
            txn(rd, n, a, d, 1'($urandom % 4 == 0), "R1 R5 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule